// File: doc/BRIEF.md
# Block-Tagged Hash Dictionary

This block is the history table of an LZ-style byte compressor. A hash of the upcoming input bytes selects a slot, and the slot remembers the most recent input position that produced that hash. A later request with the same hash gets that position back as a match candidate. Computing the hash and confirming a match by comparing bytes are done by neighbouring logic.

Each stored word carries a one-bit tag. The tag holds the value of a block flag, and the flag flips at every new data block. A slot whose tag disagrees with the flag is left over from the previous block and is reported as empty. Because of this, the RAM never needs a clearing pass and no second table is needed for ping-pong use. When an insert finds its primary slot already occupied by the current block, the position goes into a separate secondary table. The secondary slot is the hash plus a fixed offset, taken modulo the table depth.

There is one request port. Every request is a lookup, and it can also carry an insert. One cycle later the block returns the primary candidate and the secondary candidate, each with its own hit bit. If the request asked for an insert, the write happens in that same response cycle, and the placement is decided from the primary word just read.

Top module: `blk_tag_dict`

## Requirements
- R1: After reset the response strobe and both hit bits are low. Until the first block-start pulse, every request reports both hits low, and inserts write nothing.
- R2: Each accepted request (`reqValid` high at a rising edge) produces exactly one cycle of `rspValid`, right after that edge. No response appears without a request.
- R3: An insert whose primary slot at `reqHash` is not live writes the word {flag, `reqPos`} to that slot. A later lookup of that hash reports `priHit`=1 and returns that position on `priPos`.
- R4: The first block-start pulse after reset leaves the flag at 0. Every later pulse inverts it. Entries written in the previous block then report no hit.
- R5: An entry written two blocks earlier has a tag equal to the current flag and is reported as a hit. The caller must confirm it with a byte comparison.
- R6: An insert whose primary slot is live (its tag equals the flag) leaves that slot unchanged. It writes {flag, `reqPos`} to the secondary slot at (`reqHash` + `SEC_OFS`) mod 2^`HASH_W`. A lookup returns both candidates together.
- R7: The secondary address wraps modulo the depth. When the hash plus the offset passes the last index, the secondary write lands at the wrapped index, and the primary entry at that index is left unchanged.
- R8: A request to the same hash in the cycle right after an insert sees the word that insert wrote, in both the primary table and the secondary table.
- R9: A block-start pulse takes no extra cycles. A request presented in the same cycle as the pulse is evaluated and written under the new flag.
- R10: A request with `reqWrite` low changes no stored entry. Later lookups return the same candidates as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| blkStart | input | 1 | One-cycle pulse marking the start of a new data block |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | Request also inserts `reqPos` |
| reqHash | input | HASH_W | Hash of the current input string |
| reqPos | input | POS_W | Position index to store |
| rspValid | output | 1 | Response strobe, one cycle after a request |
| priHit | output | 1 | Primary candidate belongs to the current block |
| priPos | output | POS_W | Primary candidate position |
| secHit | output | 1 | Secondary candidate belongs to the current block |
| secPos | output | POS_W | Secondary candidate position |

## Verification
A flag that flips at the wrong time inverts every hit decision. This shows up at the very next lookup after a block-start pulse, as hits on stale slots or as misses on fresh ones. A wrong placement decision for an insert, or a missing forward, is visible when the same hash is looked up right after the write: the wrong table holds the position, or a position from one write earlier comes back. A secondary address that does not wrap correctly corrupts a primary-only slot near index zero. A probe of that slot reveals it at once.

// File: rtl/bdict_pkg.sv
package bdict_pkg;
  // strobes from control to datapath for the write stage
  typedef struct packed {
    logic wePri;   // write primary slot of the stage-1 hash
    logic weSec;   // write secondary slot of the stage-1 hash
    logic tagNow;  // flag value to store with the position
  } dictStrb_t;
endpackage

// File: rtl/bdict_dp.sv
module bdict_dp
  import bdict_pkg::*;
#(
  parameter int HASH_W  = 10,
  parameter int POS_W   = 16,
  parameter int SEC_OFS = 389
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HASH_W-1:0] reqHash,
  input  logic [POS_W-1:0]  reqPos,
  input  dictStrb_t         strb,
  output logic              priTag,
  output logic [POS_W-1:0]  priPosQ,
  output logic              secTag,
  output logic [POS_W-1:0]  secPosQ
);
  localparam int DEPTH  = 1 << HASH_W;
  localparam int WORD_W = POS_W + 1;
  localparam logic [HASH_W-1:0] OFS_V = HASH_W'(SEC_OFS);

  logic [WORD_W-1:0] priMem [DEPTH];
  logic [WORD_W-1:0] secMem [DEPTH];

  logic [HASH_W-1:0] secRdAddr, s1Hash, s1SecAddr;
  logic [POS_W-1:0]  s1Pos;
  logic [WORD_W-1:0] priRd, secRd, fwdWord, wrWord, priWord, secWord;
  logic              priFwd, secFwd;

  // the offset addition wraps naturally at HASH_W bits
  assign secRdAddr = reqHash + OFS_V;
  assign wrWord    = {strb.tagNow, s1Pos};

  always_ff @(posedge clk) begin
    s1Hash    <= reqHash;
    s1Pos     <= reqPos;
    s1SecAddr <= secRdAddr;
    priRd     <= priMem[reqHash];
    secRd     <= secMem[secRdAddr];
    fwdWord   <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priFwd <= 1'b0;
      secFwd <= 1'b0;
    end else begin
      priFwd <= strb.wePri && (s1Hash == reqHash);
      secFwd <= strb.weSec && (s1SecAddr == secRdAddr);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wePri) priMem[s1Hash] <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (strb.weSec) secMem[s1SecAddr] <= wrWord;
  end

  assign priWord = priFwd ? fwdWord : priRd;
  assign secWord = secFwd ? fwdWord : secRd;
  assign {priTag, priPosQ} = priWord;
  assign {secTag, secPosQ} = secWord;

  // R8: a same-slot read right after a write returns the written word
  p_fwd_pri_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wePri && s1Hash == reqHash) |=>
      (priTag == $past(strb.tagNow) && priPosQ == $past(s1Pos)));
  p_fwd_sec_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.weSec && s1SecAddr == secRdAddr) |=>
      (secTag == $past(strb.tagNow) && secPosQ == $past(s1Pos)));
endmodule

// File: rtl/bdict_ctrl.sv
module bdict_ctrl
  import bdict_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      blkStart,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      priTag,
  input  logic      secTag,
  output dictStrb_t strb,
  output logic      rspValid,
  output logic      priHit,
  output logic      secHit
);
  logic flag, started, s1Valid, s1Write;
  logic priLive, secLive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag    <= 1'b0;
      started <= 1'b0;
      s1Valid <= 1'b0;
      s1Write <= 1'b0;
    end else begin
      s1Valid <= reqValid;
      s1Write <= reqValid && reqWrite;
      if (blkStart) begin
        started <= 1'b1;
        if (started) flag <= ~flag;
      end
    end
  end

  assign priLive  = started && (priTag == flag);
  assign secLive  = started && (secTag == flag);
  assign rspValid = s1Valid;
  assign priHit   = s1Valid && priLive;
  assign secHit   = s1Valid && secLive;

  always_comb begin
    strb.tagNow = flag;
    strb.wePri  = s1Write && started && !priLive;
    strb.weSec  = s1Write && priLive;
  end

  p_lat_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_nolat_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  p_prestart_r1: assert property (@(posedge clk) disable iff (!rstN)
    !started |-> (!priHit && !secHit && !strb.wePri && !strb.weSec));
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !blkStart |=> $stable(flag));
  p_flag_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
    (blkStart && started) |=> (flag != $past(flag)));
  p_one_wr_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wePri, strb.weSec}));
endmodule

// File: rtl/blk_tag_dict.sv
module blk_tag_dict
  import bdict_pkg::*;
#(
  parameter int HASH_W  = 10,
  parameter int POS_W   = 16,
  parameter int SEC_OFS = 389
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              blkStart,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [HASH_W-1:0] reqHash,
  input  logic [POS_W-1:0]  reqPos,
  output logic              rspValid,
  output logic              priHit,
  output logic [POS_W-1:0]  priPos,
  output logic              secHit,
  output logic [POS_W-1:0]  secPos
);
  dictStrb_t strb;
  logic      priTag, secTag;

  bdict_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .blkStart (blkStart),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .priTag   (priTag),
    .secTag   (secTag),
    .strb     (strb),
    .rspValid (rspValid),
    .priHit   (priHit),
    .secHit   (secHit)
  );

  bdict_dp #(
    .HASH_W  (HASH_W),
    .POS_W   (POS_W),
    .SEC_OFS (SEC_OFS)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqHash (reqHash),
    .reqPos  (reqPos),
    .strb    (strb),
    .priTag  (priTag),
    .priPosQ (priPos),
    .secTag  (secTag),
    .secPosQ (secPos)
  );
endmodule

// File: tb/blk_tag_dict_tb_top.sv
module blk_tag_dict_tb_top;
  localparam int HASH_W  = 10;
  localparam int POS_W   = 16;
  localparam int SEC_OFS = 389;
  localparam int DEPTH   = 1 << HASH_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic blkStart = 1'b0, reqValid = 1'b0, reqWrite = 1'b0;
  logic [HASH_W-1:0] reqHash = '0;
  logic [POS_W-1:0]  reqPos = '0;
  logic rspValid, priHit, secHit;
  logic [POS_W-1:0] priPos, secPos;

  always #5 clk = ~clk;

  blk_tag_dict #(.HASH_W(HASH_W), .POS_W(POS_W), .SEC_OFS(SEC_OFS)) dut_i (
    .clk(clk), .rstN(rstN), .blkStart(blkStart), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqHash(reqHash), .reqPos(reqPos),
    .rspValid(rspValid), .priHit(priHit), .priPos(priPos),
    .secHit(secHit), .secPos(secPos)
  );

  typedef struct {
    int cyc; bit chkHit; bit chkPos;
    bit pHit; bit sHit; logic [POS_W-1:0] pPos; logic [POS_W-1:0] sPos;
    string tag;
  } exp_t;
  exp_t q[$];

  int total = 0, bad = 0, cyc = 0;
  bit mFlag = 0, mStarted = 0, modelSure = 0;
  bit               mPriTag [DEPTH];
  logic [POS_W-1:0] mPriPos [DEPTH];
  bit               mSecTag [DEPTH];
  logic [POS_W-1:0] mSecPos [DEPTH];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // driver: one request per call, back-to-back when called in a row
  task automatic issue(int h, int p, bit w, bit blk, string tag);
    exp_t e;
    int s;
    @(negedge clk);
    blkStart = blk; reqValid = 1'b1; reqWrite = w;
    reqHash = HASH_W'(h); reqPos = POS_W'(p);
    if (blk) begin
      if (mStarted) mFlag = ~mFlag;
      mStarted = 1;
    end
    s = (h + SEC_OFS) % DEPTH;
    e.cyc = cyc; e.tag = tag;
    e.chkHit = !mStarted || modelSure;
    e.chkPos = modelSure;
    e.pHit = mStarted && (mPriTag[h] == mFlag);
    e.sHit = mStarted && (mSecTag[s] == mFlag);
    e.pPos = mPriPos[h];
    e.sPos = mSecPos[s];
    if (w && mStarted) begin
      if (e.pHit) begin mSecTag[s] = mFlag; mSecPos[s] = POS_W'(p); end
      else        begin mPriTag[h] = mFlag; mPriPos[h] = POS_W'(p); end
    end
    q.push_back(e);
  endtask

  task automatic idle(bit blk);
    @(negedge clk);
    blkStart = blk; reqValid = 1'b0; reqWrite = 1'b0;
    if (blk) begin
      if (mStarted) mFlag = ~mFlag;
      mStarted = 1;
    end
  endtask

  // monitor: compare responses against the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rspValid) begin
        if (q.size() == 0) begin
          check(0, "R2", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(e.cyc + 1 == cyc, "R2", "response latency", cyc - e.cyc, 1);
          if (e.chkHit) begin
            check(priHit == e.pHit, e.tag, "priHit", priHit, e.pHit);
            check(secHit == e.sHit, e.tag, "secHit", secHit, e.sHit);
          end
          if (e.chkPos && e.pHit)
            check(priPos == e.pPos, e.tag, "priPos", priPos, e.pPos);
          if (e.chkPos && e.sHit)
            check(secPos == e.sPos, e.tag, "secPos", secPos, e.sPos);
        end
      end else if (q.size() > 0 && cyc >= q[0].cyc + 1) begin
        void'(q.pop_front());
        check(0, "R2", "missing response", 0, 1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rspValid == 0, "R1", "rspValid after reset", rspValid, 0);
    check(priHit == 0 && secHit == 0, "R1", "hits after reset", priHit | secHit, 0);
    // R1: before the first block nothing hits and inserts are dropped
    issue(7, 11, 1, 0, "R1");
    issue(7, 12, 1, 0, "R1");
    issue(7, 0, 0, 0, "R1");
    idle(1);   // block 0, flag 0
    idle(0);
    idle(1);   // block 1, flag 1
    // fill both tables under flag 1 so every slot is known
    for (int h = 0; h < DEPTH; h++) begin
      issue(h, h + 1000, 1, 0, "FILL");
      issue(h, h + 3000, 1, 0, "FILL");
    end
    idle(0); idle(0);
    modelSure = 1;
    // R4: new block, old entries stale
    idle(1);   // flag 0
    issue(5, 0, 0, 0, "R4");
    issue(40, 0, 0, 0, "R10");
    // R3 and R8: insert then same-hash lookup back-to-back
    issue(5, 100, 1, 0, "R3");
    issue(5, 0, 0, 0, "R8");
    idle(0);
    issue(5, 0, 0, 0, "R3");
    // R6: collision goes to secondary
    issue(5, 200, 1, 0, "R6");
    idle(0);
    issue(5, 0, 0, 0, "R6");
    // R8: chained inserts, secondary forwarding
    issue(9, 1, 1, 0, "R8");
    issue(9, 2, 1, 0, "R8");
    issue(9, 0, 0, 0, "R8");
    idle(0);
    // R7: wrap of secondary address
    issue(DEPTH - 1, 500, 1, 0, "R7");
    idle(0);
    issue(DEPTH - 1, 501, 1, 0, "R7");
    idle(0);
    issue(DEPTH - 1, 0, 0, 0, "R7");
    issue((DEPTH - 1 + SEC_OFS) % DEPTH, 0, 0, 0, "R7");
    issue(40, 0, 0, 0, "R10");
    idle(0);
    // R5: block 3 (flag 1) sees block-1 entries again
    idle(1);
    issue(20, 0, 0, 0, "R5");
    issue(5, 0, 0, 0, "R5");
    // R9: request together with block start uses the new flag
    issue(30, 777, 1, 1, "R9");   // flag 0
    issue(30, 0, 0, 0, "R9");
    idle(0);
    issue(20, 0, 0, 0, "R9");
    // mixed traffic on a few hashes
    for (int i = 0; i < 400; i++) begin
      int h;
      h = ($urandom % 4 == 0) ? DEPTH - 1 - ($urandom % 3) : $urandom % 12;
      issue(h, $urandom % 65536, $urandom % 2, ($urandom % 40) == 0, "R3");
      if ($urandom % 3 == 0) idle(0);
    end
    idle(0); idle(0); idle(0);
    check(q.size() == 0, "R2", "responses outstanding", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule